// File: doc/BRIEF.md
# Three-Wire Half-Duplex SPI Port

This block is an SPI port whose serial data travels over one shared, bidirectional line rather than a separate data-in and data-out pair. It works as the clocking master or as a slave. A transmit-enable control bit decides whether the port drives the shared line during a transfer. When the port drives the line it also samples the line, so it gets its own outgoing bits back as a junk word. When it does not drive the line it only listens, and it receives whatever the far end puts on the line.

Software uses a small register-style interface. Address 0 is the data word and address 1 is the control word on writes or the status word on reads. In master mode, any write of the data word starts a 16-bit transfer. With the transmit path closed, that write is a dummy whose only job is to produce the sixteen clocks. In slave mode, the written word waits until the external master asserts select. A full-word flag and an interrupt output mark each completed word. Reading the receive buffer clears the flag.

The serial format is fixed. Words are shifted MSB first. The clock idles low, data is sampled on its rising edge and changed on its falling edge. The master derives its serial clock by dividing the system clock by a programmable amount.

Top module: `spi3w_port`

## Requirements
- R1: After reset, sd_oe is 0, ss_n_o is 1, sclk_o is 0, irq is 0 and the status word (address 1) reads 0.
- R2: In master mode (control bit 0 = 1), a write to address 0 while idle drives ss_n_o low in the following cycle with sclk_o still low. sclk_o rises one cycle after that and produces exactly 16 rising edges. ss_n_o returns high one cycle after the final falling edge.
- R3: The divisor N is taken from control bits [15:8] and clamped to the range 2..128. The serial clock period is N system clocks, with the high phase lasting floor(N/2) clocks.
- R4: With transmit enable set (control bit 1 = 1) in master mode, sd_oe is high for the whole select-active window. The written word leaves on sd_o MSB first, and sd_o changes only when sclk_o falls. The word sampled back from the line is then held in the receive buffer.
- R5: With transmit enable clear in master mode, a write to address 0 still runs a complete transfer, but sd_oe stays 0 throughout. The receive buffer then holds the 16 bits that the far end drove on the line.
- R6: When the 16th rising edge of a word is sampled, status bit 0 and irq go high. A read of address 0 returns the word and clears both.
- R7: If a word completes while status bit 0 is still set, status bit 1 (overrun) goes high and the new word replaces the old one. A read of address 1 clears bit 1.
- R8: In slave mode (control bit 0 = 0), ss_n_o stays high and sclk_o stays low, and a data write starts no activity. While ss_n_i is low with transmit enable set, the port drives the written word MSB first, changing bits after sclk_i falls. It also captures the line on sclk_i rising edges, which leaves its own word in the receive buffer.
- R9: In slave mode with transmit enable clear, sd_oe stays 0 and the word the master drives on the line is received.
- R10: In master mode, status bit 2 (busy) reads 1 while select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 data word, 1 control word |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; applies the clear-on-read side effects |
| rd_addr | input | 1 | Read source: 0 receive buffer, 1 status word |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| irq | output | 1 | High while an unread received word is held |
| sclk_o | output | 1 | Serial clock driven in master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| sclk_i | input | 1 | Serial clock from an external master (slave mode) |
| ss_n_i | input | 1 | Active-low select from an external master (slave mode) |
| sd_i | input | 1 | Level seen on the shared data pin |
| sd_o | output | 1 | Value driven onto the shared data pin |
| sd_oe | output | 1 | Output enable of the shared data pin driver |

## Verification
Some properties are checked on every cycle. The serial clock never toggles outside a select-active window, and the data driver never turns on without transmit enable. A slave never drives clock or select. The interrupt rises only on a completed word, a word lost to an unread buffer always raises overrun, and master data holds between falling clock edges. Other behaviour only the directed scenarios can show. These cover the exact clock period and high time for even, odd and clamped divisors, and the bit content in each case: loopback junk, a dummy-clocked receive from a modelled slave, and slave transmit and receive against a modelled master across the input synchronizers.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

   localparam int CTRL_USED_W  = 16;
   localparam int CTRL_MASTER  = 0;
   localparam int CTRL_TXEN    = 1;
   localparam int DIV_LSB      = 8;
   localparam int DIV_FIELD_W  = 8;

   localparam int STAT_FULL    = 0;
   localparam int STAT_OVR     = 1;
   localparam int STAT_BUSY    = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_HIGH,
      PH_LOW,
      PH_TRAIL
   } mphase_t;

   typedef struct packed {
      logic [DIV_FIELD_W-1:0] div;
      logic                   tx_en;
      logic                   master;
   } ctrl_t;

endpackage

// File: rtl/spi3w_mclk.sv
module spi3w_mclk
   import spi3w_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int DIV_MAX = 128
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             go,
   input  logic [$clog2(DIV_MAX+1)-1:0]     div_eff,
   output logic                             sclk,
   output logic                             ss_n,
   output logic                             rise,
   output logic                             fall
);
   localparam int DVW = $clog2(DIV_MAX+1);
   localparam int CW  = $clog2(WORD_W+1);

   mphase_t        st;
   logic [DVW-1:0] ph;
   logic [CW-1:0]  nrise;
   logic [DVW-1:0] hi_len;
   logic [DVW-1:0] lo_len;

   always_comb begin
      hi_len = div_eff >> 1;
      lo_len = div_eff - hi_len;
      rise   = (st == PH_LEAD) || (st == PH_LOW && ph == '0);
      fall   = (st == PH_HIGH) && (ph == '0);
      sclk   = (st == PH_HIGH);
      ss_n   = (st == PH_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= PH_IDLE;
         ph    <= '0;
         nrise <= '0;
      end else begin
         case (st)
            PH_IDLE: if (go) st <= PH_LEAD;
            PH_LEAD: begin
               st    <= PH_HIGH;
               ph    <= hi_len - 1'b1;
               nrise <= CW'(1);
            end
            PH_HIGH: begin
               if (ph == '0) begin
                  if (nrise == CW'(WORD_W)) begin
                     st <= PH_TRAIL;
                  end else begin
                     st <= PH_LOW;
                     ph <= lo_len - 1'b1;
                  end
               end else begin
                  ph <= ph - 1'b1;
               end
            end
            PH_LOW: begin
               if (ph == '0) begin
                  st    <= PH_HIGH;
                  ph    <= hi_len - 1'b1;
                  nrise <= nrise + 1'b1;
               end else begin
                  ph <= ph - 1'b1;
               end
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi3w_ssync.sv
module spi3w_ssync #(
   parameter int SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic ss_n_i,
   input  logic sd_i,
   output logic start,
   output logic rise,
   output logic fall,
   output logic active,
   output logic sd_s
);
   localparam int CHW = 3 * SYNC_STAGES;
   localparam logic [2:0] IDLE_LVL = 3'b011;

   logic [CHW-1:0] chain;
   logic           sclk_s, ss_s;
   logic           sclk_d, ss_d;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi3w_ssync needs at least two synchronizer stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {SYNC_STAGES{IDLE_LVL}};
         sclk_d <= 1'b0;
         ss_d   <= 1'b1;
      end else begin
         chain  <= {chain[CHW-4:0], sclk_i, ss_n_i, sd_i};
         sclk_d <= sclk_s;
         ss_d   <= ss_s;
      end
   end

   always_comb begin
      sclk_s = chain[CHW-1];
      ss_s   = chain[CHW-2];
      sd_s   = chain[CHW-3];
      active = !ss_s;
      start  = ss_d && !ss_s;
      rise   = active && !sclk_d && sclk_s;
      fall   = active && sclk_d && !sclk_s;
   end

endmodule

// File: rtl/spi3w_shifter.sv
module spi3w_shifter #(
   parameter int WORD_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              rise,
   input  logic              fall,
   input  logic              sd_in,
   output logic              sd_out,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);
   localparam int CW = $clog2(WORD_W+1);

   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;
   logic [CW-1:0]     cnt;

   always_comb begin
      sd_out  = tx_sh[WORD_W-1];
      rx_word = {rx_sh[WORD_W-2:0], sd_in};
      done    = rise && (cnt == CW'(WORD_W-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
         cnt   <= '0;
      end else if (load) begin
         tx_sh <= load_word;
         cnt   <= '0;
      end else begin
         if (rise) begin
            rx_sh <= rx_word;
            if (cnt != CW'(WORD_W)) cnt <= cnt + 1'b1;
         end
         if (fall) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/spi3w_port.sv
module spi3w_port
   import spi3w_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int DIV_MIN     = 2,
   parameter int DIV_MAX     = 128,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic              wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              irq,
   output logic              sclk_o,
   output logic              ss_n_o,
   input  logic              sclk_i,
   input  logic              ss_n_i,
   input  logic              sd_i,
   output logic              sd_o,
   output logic              sd_oe
);
   localparam int DVW = $clog2(DIV_MAX+1);

   generate
      if (WORD_W < CTRL_USED_W) begin : g_bad_word
         $error("spi3w_port: WORD_W must hold the control word");
      end
      if (DIV_MIN < 2 || DIV_MAX < DIV_MIN) begin : g_bad_div
         $error("spi3w_port: divisor range invalid");
      end
      if (DIV_MAX >= (1 << DIV_FIELD_W)) begin : g_bad_divmax
         $error("spi3w_port: DIV_MAX exceeds the divisor field");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [WORD_W-1:0] tx_buf;
   logic [WORD_W-1:0] rx_buf;
   logic              rx_full;
   logic              ovr;
   logic [DVW-1:0]    div_eff;

   logic              is_master, tx_en;
   logic              wr_data_sel, wr_ctrl_sel, rd_rx, rd_stat;
   logic              go;

   logic              m_sclk, m_ss_n, m_rise, m_fall;
   logic              s_start, s_rise, s_fall, s_active, s_sd;

   logic              sh_load, sh_rise, sh_fall, sh_in;
   logic [WORD_W-1:0] sh_word;
   logic              done;
   logic [WORD_W-1:0] rx_word;
   logic              sh_out;

   always_comb begin
      is_master   = ctrl_q.master;
      tx_en       = ctrl_q.tx_en;
      wr_data_sel = wr_valid && !wr_addr;
      wr_ctrl_sel = wr_valid && wr_addr;
      rd_rx       = rd_en && !rd_addr;
      rd_stat     = rd_en && rd_addr;
      go          = is_master && wr_data_sel && m_ss_n;

      if (ctrl_q.div < DIV_FIELD_W'(DIV_MIN))
         div_eff = DVW'(DIV_MIN);
      else if (ctrl_q.div > DIV_FIELD_W'(DIV_MAX))
         div_eff = DVW'(DIV_MAX);
      else
         div_eff = DVW'(ctrl_q.div);
   end

   spi3w_mclk #(
      .WORD_W  (WORD_W),
      .DIV_MAX (DIV_MAX)
   ) u_mclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .div_eff (div_eff),
      .sclk    (m_sclk),
      .ss_n    (m_ss_n),
      .rise    (m_rise),
      .fall    (m_fall)
   );

   spi3w_ssync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_ssync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk_i),
      .ss_n_i (ss_n_i),
      .sd_i   (sd_i),
      .start  (s_start),
      .rise   (s_rise),
      .fall   (s_fall),
      .active (s_active),
      .sd_s   (s_sd)
   );

   always_comb begin
      if (is_master) begin
         sh_load = go;
         sh_word = wr_data;
         sh_rise = m_rise;
         sh_fall = m_fall;
         sh_in   = sd_i;
      end else begin
         sh_load = s_start;
         sh_word = tx_buf;
         sh_rise = s_rise;
         sh_fall = s_fall;
         sh_in   = s_sd;
      end
   end

   spi3w_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_word (sh_word),
      .rise      (sh_rise),
      .fall      (sh_fall),
      .sd_in     (sh_in),
      .sd_out    (sh_out),
      .done      (done),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q.div    <= DIV_FIELD_W'(4);
         ctrl_q.tx_en  <= 1'b0;
         ctrl_q.master <= 1'b0;
         tx_buf        <= '0;
      end else begin
         if (wr_ctrl_sel) begin
            ctrl_q.div    <= wr_data[DIV_LSB +: DIV_FIELD_W];
            ctrl_q.tx_en  <= wr_data[CTRL_TXEN];
            ctrl_q.master <= wr_data[CTRL_MASTER];
         end
         if (wr_data_sel) tx_buf <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf  <= '0;
         rx_full <= 1'b0;
         ovr     <= 1'b0;
      end else begin
         if (done) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
         end else if (rd_rx) begin
            rx_full <= 1'b0;
         end
         if (done && rx_full && !rd_rx) ovr <= 1'b1;
         else if (rd_stat)              ovr <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (!rd_addr) begin
         rd_data = rx_buf;
      end else begin
         rd_data[STAT_FULL] = rx_full;
         rd_data[STAT_OVR]  = ovr;
         rd_data[STAT_BUSY] = is_master && !m_ss_n;
      end
      irq    = rx_full;
      sclk_o = is_master && m_sclk;
      ss_n_o = !is_master || m_ss_n;
      sd_o   = sh_out;
      sd_oe  = tx_en && (is_master ? !m_ss_n : s_active);
   end

endmodule

// File: rtl/spi3w_port_chk.sv
module spi3w_port_chk (
   input logic clk,
   input logic rst_n,
   input logic is_master,
   input logic tx_en,
   input logic sclk_o,
   input logic ss_n_o,
   input logic sd_o,
   input logic sd_oe,
   input logic irq,
   input logic done,
   input logic rx_full,
   input logic ovr,
   input logic rd_rx
);

   AST_SCLK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !ss_n_o); // R2

   AST_OE_NEEDS_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
      sd_oe |-> tx_en); // R5

   AST_SLAVE_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !is_master |-> (ss_n_o && !sclk_o)); // R8

   AST_IRQ_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(done)); // R6

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_full && !rd_rx) |=> ovr); // R7

   AST_MDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && !ss_n_o && $past(!ss_n_o) && !$fell(sclk_o)) |-> $stable(sd_o)); // R4

endmodule

bind spi3w_port spi3w_port_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .is_master (is_master),
   .tx_en     (tx_en),
   .sclk_o    (sclk_o),
   .ss_n_o    (ss_n_o),
   .sd_o      (sd_o),
   .sd_oe     (sd_oe),
   .irq       (irq),
   .done      (done),
   .rx_full   (rx_full),
   .ovr       (ovr),
   .rd_rx     (rd_rx)
);

// File: tb/spi3w_port_bench.sv
module spi3w_port_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic        wr_addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic        rd_addr = 1'b0;
   logic [15:0] rd_data;
   logic        irq;
   logic        sclk_o, ss_n_o;
   logic        sclk_i = 1'b0;
   logic        ss_n_i = 1'b1;
   logic        sd_o, sd_oe;
   logic        line;

   logic        pmodel_on = 1'b0;
   logic [15:0] pword = '0;
   logic [15:0] psh = '0;
   logic        bm_oe = 1'b0;
   logic        bm_o = 1'b1;

   int          n_chk = 0;
   int          n_err = 0;
   int          rise_cnt = 0;
   time         t_r1 = 0, t_r2 = 0, t_f1 = 0;
   logic [15:0] cap = '0;
   bit          oe_seen = 1'b0;

   always #5 clk = ~clk;

   assign line = sd_oe ? sd_o :
                 (pmodel_on && !ss_n_o) ? psh[15] :
                 bm_oe ? bm_o : 1'b1;

   spi3w_port u_spi3w_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .irq      (irq),
      .sclk_o   (sclk_o),
      .ss_n_o   (ss_n_o),
      .sclk_i   (sclk_i),
      .ss_n_i   (ss_n_i),
      .sd_i     (line),
      .sd_o     (sd_o),
      .sd_oe    (sd_oe)
   );

   // slave model used while the port is the master
   always @(negedge ss_n_o) if (pmodel_on) psh = pword;
   always @(negedge sclk_o) if (pmodel_on) psh = {psh[14:0], 1'b0};

   // master-side monitors
   always @(posedge sclk_o) begin
      rise_cnt = rise_cnt + 1;
      if (rise_cnt == 1) t_r1 = $time;
      if (rise_cnt == 2) t_r2 = $time;
      cap = {cap[14:0], line};
   end
   always @(negedge sclk_o) if (rise_cnt == 1) t_f1 = $time;
   always @(negedge clk) if (sd_oe) oe_seen = 1'b1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic a, input logic [15:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic read_reg(input logic a, output logic [15:0] d);
      @(negedge clk);
      rd_addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic clear_mon();
      rise_cnt = 0; cap = '0; oe_seen = 1'b0;
   endtask

   task automatic wait_master_end();
      for (int i = 0; i < 5000 && !ss_n_o; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic slave_xfer(input logic [15:0] send, input bit drive, output logic [15:0] got);
      got = '0;
      @(negedge clk);
      ss_n_i = 1'b0;
      repeat (10) @(negedge clk);
      for (int b = 15; b >= 0; b--) begin
         bm_o = send[b]; bm_oe = drive;
         repeat (8) @(negedge clk);
         got = {got[14:0], line};
         sclk_i = 1'b1;
         repeat (8) @(negedge clk);
         sclk_i = 1'b0;
      end
      repeat (8) @(negedge clk);
      ss_n_i = 1'b1; bm_oe = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      check("R1 sd_oe", 32'(sd_oe), 32'd0);
      check("R1 ss_n_o", 32'(ss_n_o), 32'd1);
      check("R1 sclk_o", 32'(sclk_o), 32'd0);
      check("R1 irq", 32'(irq), 32'd0);
      read_reg(1'b1, d);
      check("R1 status", 32'(d), 32'd0);
   endtask

   task automatic t_master_loop();
      logic [15:0] d;
      write_reg(1'b1, 16'h0403);
      clear_mon();
      write_reg(1'b0, 16'hA53C);
      check("R2 select low after write", 32'(ss_n_o), 32'd0);
      check("R2 clock low in lead cycle", 32'(sclk_o), 32'd0);
      @(negedge clk);
      check("R2 first rise next cycle", 32'(sclk_o), 32'd1);
      read_reg(1'b1, d);
      check("R10 busy bit", 32'(d[2]), 32'd1);
      wait_master_end();
      check("R2 sixteen rising edges", 32'(rise_cnt), 32'd16);
      check("R3 period div 4", 32'(t_r2 - t_r1), 32'd40);
      check("R3 high time div 4", 32'(t_f1 - t_r1), 32'd20);
      check("R4 bits on line", 32'(cap), 32'hA53C);
      check("R4 driver enabled", 32'(oe_seen), 32'd1);
      check("R6 irq after word", 32'(irq), 32'd1);
      read_reg(1'b1, d);
      check("R6 full flag", 32'(d[0]), 32'd1);
      check("R10 busy clear at end", 32'(d[2]), 32'd0);
      read_reg(1'b0, d);
      check("R4 own word captured", 32'(d), 32'hA53C);
      check("R6 irq cleared by read", 32'(irq), 32'd0);
   endtask

   task automatic t_master_dummy();
      logic [15:0] d;
      write_reg(1'b1, 16'h0501);
      pmodel_on = 1'b1; pword = 16'h3C96;
      clear_mon();
      write_reg(1'b0, 16'hFFFF);
      wait_master_end();
      pmodel_on = 1'b0;
      check("R5 driver stays off", 32'(oe_seen), 32'd0);
      check("R5 transfer still clocked", 32'(rise_cnt), 32'd16);
      check("R3 period div 5", 32'(t_r2 - t_r1), 32'd50);
      check("R3 high time div 5", 32'(t_f1 - t_r1), 32'd20);
      read_reg(1'b0, d);
      check("R5 word from far end", 32'(d), 32'h3C96);
   endtask

   task automatic t_clamp();
      logic [15:0] d;
      write_reg(1'b1, 16'h0001);
      clear_mon();
      write_reg(1'b0, 16'h0000);
      wait_master_end();
      check("R3 divisor clamped low", 32'(t_r2 - t_r1), 32'd20);
      read_reg(1'b0, d);
      write_reg(1'b1, 16'hC801);
      clear_mon();
      write_reg(1'b0, 16'h0000);
      wait_master_end();
      check("R3 divisor clamped high", 32'(t_r2 - t_r1), 32'd1280);
      check("R3 high time clamped high", 32'(t_f1 - t_r1), 32'd640);
      read_reg(1'b0, d);
   endtask

   task automatic t_overrun();
      logic [15:0] d;
      write_reg(1'b1, 16'h0201);
      pmodel_on = 1'b1; pword = 16'h1111;
      clear_mon();
      write_reg(1'b0, 16'h0000);
      wait_master_end();
      pword = 16'h2222;
      write_reg(1'b0, 16'h0000);
      wait_master_end();
      pmodel_on = 1'b0;
      read_reg(1'b1, d);
      check("R7 overrun set", 32'(d[1]), 32'd1);
      check("R7 full still set", 32'(d[0]), 32'd1);
      read_reg(1'b1, d);
      check("R7 overrun cleared by status read", 32'(d[1]), 32'd0);
      read_reg(1'b0, d);
      check("R7 newest word kept", 32'(d), 32'h2222);
   endtask

   task automatic t_slave_tx();
      logic [15:0] d, got;
      write_reg(1'b1, 16'h0402);
      write_reg(1'b0, 16'hC3A5);
      repeat (20) @(negedge clk);
      check("R8 no select from slave", 32'(ss_n_o), 32'd1);
      check("R8 no clock from slave", 32'(sclk_o), 32'd0);
      check("R8 no drive while unselected", 32'(sd_oe), 32'd0);
      check("R8 write starts nothing", 32'(irq), 32'd0);
      oe_seen = 1'b0;
      slave_xfer(16'h0000, 1'b0, got);
      check("R8 slave word on line", 32'(got), 32'hC3A5);
      check("R8 slave drove line", 32'(oe_seen), 32'd1);
      check("R8 word flagged", 32'(irq), 32'd1);
      read_reg(1'b0, d);
      check("R8 junk word is own data", 32'(d), 32'hC3A5);
   endtask

   task automatic t_slave_rx();
      logic [15:0] d, got;
      write_reg(1'b1, 16'h0400);
      oe_seen = 1'b0;
      slave_xfer(16'h5AE1, 1'b1, got);
      check("R9 driver stays off", 32'(oe_seen), 32'd0);
      check("R9 word flagged", 32'(irq), 32'd1);
      read_reg(1'b0, d);
      check("R9 received word", 32'(d), 32'h5AE1);
   endtask

   initial begin
      #1_500_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_master_loop();
      t_master_dummy();
      t_clamp();
      t_overrun();
      t_slave_tx();
      t_slave_rx();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule